// File: doc/BRIEF.md
# Quarter-Phased Local Memory Bus Multiplexer

This block turns an oscillator clock into the timing frame of a local memory bus. Each bus-clock period is split into four quarters. Two bus clocks come out of the block, the second trailing the first by one quarter. A divide-select input sets how many oscillator cycles make up a quarter. The quarter counter runs all the time, so the bus clocks keep toggling whether or not a memory cycle is in progress.

A requester presents a 24-bit address, 16 bits of write data, a write flag and a one-cycle start strobe. The block then runs a memory cycle over the next whole Q1..Q4 frame. Three shared pins change meaning from quarter to quarter. In the first half of the frame they carry the extended (upper) address bits. In the second half they carry byte parity, except for one pin, which carries a column-address bit. The block also drives an active-low data-buffer enable during the data half of the cycle and an active-low output enable for a 16-word identity ROM at the bottom of the address space.

Top module: `qphase_membus`

## Requirements
- R1: `bclk_lead` is high in Q1 and Q2 and low in Q3 and Q4. `bclk_lag` is high in Q2 and Q3. So `bclk_lag` rises and falls exactly one quarter after `bclk_lead`. The quarter can be read from the pair {lead,lag}: 10=Q1, 11=Q2, 01=Q3, 00=Q4.
- R2: With `div_sel`=1, each quarter lasts 2 oscillator cycles, so the bus-clock period is 8 oscillator cycles.
- R3: With `div_sel`=0, each quarter lasts 1 oscillator cycle, so the bus-clock period is 4 oscillator cycles.
- R4: During a cycle, `xa_hi` carries address bit 21 in Q1, address bit 20 in Q2, and the parity of data bits 15:8 in Q3 and Q4.
- R5: During a cycle, `xa_lo` carries address bit 23 in Q1, address bit 22 in Q2, and the parity of data bits 7:0 in Q3 and Q4.
- R6: During a cycle, `xa_ext` carries address bit 22 in Q1 and address bit 14 in Q2, Q3 and Q4.
- R7: Parity is odd: the byte and its parity bit together hold an odd number of ones. On a write (`wr`=1) it is taken from the latched write data. On a read it is taken from `rd_data`.
- R8: `buf_en_n` is low only in Q3 and Q4 of an active cycle. It is high at every other time.
- R9: `rom_en_n` is low for the whole of an active read cycle whose address is 0x000000..0x00000F. It is high for writes to that range, for any access elsewhere, and when the bus is idle.
- R10: A start strobe sampled while the bus is idle starts a cycle at the next Q4-to-Q1 boundary, including a boundary on the same edge. The request is captured at the strobe. A start strobe sampled while a cycle is active, or while a request is already waiting, is ignored.
- R11: While reset is asserted, the bus is in Q1 (`bclk_lead`=1, `bclk_lag`=0) and idle, with `buf_en_n`=1 and `rom_en_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | 1: quarter = 2 oscillator cycles; 0: quarter = 1 |
| start | input | 1 | Cycle request strobe |
| addr | input | 24 | Request address |
| wdata | input | 16 | Request write data |
| wr | input | 1 | 1 = write, 0 = read |
| rd_data | input | 16 | Data bus value during a read |
| bclk_lead | output | 1 | Leading bus clock |
| bclk_lag | output | 1 | Bus clock one quarter behind |
| xa_hi | output | 1 | High-byte extended address / parity pin |
| xa_lo | output | 1 | Low-byte extended address / parity pin |
| xa_ext | output | 1 | Extended address / column bit pin |
| buf_en_n | output | 1 | Active-low data-buffer enable |
| rom_en_n | output | 1 | Active-low identity-ROM enable |

## Verification
The hardest cases to reach are the ones where a strobe lands exactly on a frame boundary: on the edge where Q4 turns into Q1, or while an earlier request is still waiting for that boundary. The stimulus pulses a second strobe one oscillator cycle after the first, and a third in Q2 of a running cycle. Because the divide mode is chosen at random per transaction, the first strobe lands at every quarter offset, in both quarter lengths. The bench reads the quarter from the bus clock pair. It then checks that only the first request ever reaches the pins and that the frame after the cycle stays idle.

// File: rtl/qpm_pkg.sv
package qpm_pkg;

  typedef enum logic [1:0] {
    QTR_1 = 2'd0,
    QTR_2 = 2'd1,
    QTR_3 = 2'd2,
    QTR_4 = 2'd3
  } qtr_e;

  // successor quarter, wrapping Q4 -> Q1
  function automatic qtr_e next_qtr(input qtr_e q);
    case (q)
      QTR_1:   return QTR_2;
      QTR_2:   return QTR_3;
      QTR_3:   return QTR_4;
      default: return QTR_1;
    endcase
  endfunction

  // leading bus clock is high for the first half of the frame
  function automatic logic lead_level(input qtr_e q);
    return (q == QTR_1) || (q == QTR_2);
  endfunction

  // trailing bus clock: same shape, one quarter later
  function automatic logic lag_level(input qtr_e q);
    return (q == QTR_2) || (q == QTR_3);
  endfunction

  // odd parity bit: byte plus bit has an odd number of ones
  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction

  // second half of the frame carries data
  function automatic logic data_half(input qtr_e q);
    return (q == QTR_3) || (q == QTR_4);
  endfunction

endpackage

// File: rtl/qpm_clkgen.sv
module qpm_clkgen
  import qpm_pkg::*;
#(
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel,
  output logic tick,
  output qtr_e qtr,
  output logic bclk_lead,
  output logic bclk_lag
);

  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] pre_cnt;
  logic          pre_wrap;

  assign pre_wrap = (pre_cnt == CW'(SLOW_DIV - 1));
  assign tick     = !div_sel || pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr <= QTR_1;
    end else if (tick) begin
      qtr <= next_qtr(qtr);
    end
  end

  assign bclk_lead = lead_level(qtr);
  assign bclk_lag  = lag_level(qtr);

  AST_LAG_ONE_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (bclk_lag == $past(bclk_lead))); // R1

  AST_SLOW_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel) |=> (!tick || !div_sel)); // R2

  AST_FAST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !div_sel |=> (qtr != $past(qtr))); // R3

endmodule

// File: rtl/qpm_seq.sv
module qpm_seq
  import qpm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  qtr_e              qtr,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic              active,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata,
  output logic              cyc_wr,
  output logic              cyc_begin,
  output logic              cyc_end
);

  logic              pend;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_wr;
  logic              boundary;
  logic              take_req;

  assign boundary  = tick && (qtr == QTR_4);
  assign cyc_begin = boundary && !active && (pend || start);
  assign cyc_end   = boundary && active;
  assign take_req  = !active && !pend && start && !boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
    end else if (cyc_end) begin
      active <= 1'b0;
    end else if (cyc_begin) begin
      active <= 1'b1;
      pend   <= 1'b0;
    end else if (take_req) begin
      pend   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr  <= '0;
      req_wdata <= '0;
      req_wr    <= 1'b0;
    end else if (take_req) begin
      req_addr  <= addr;
      req_wdata <= wdata;
      req_wr    <= wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_addr  <= '0;
      cyc_wdata <= '0;
      cyc_wr    <= 1'b0;
    end else if (cyc_begin) begin
      cyc_addr  <= pend ? req_addr  : addr;
      cyc_wdata <= pend ? req_wdata : wdata;
      cyc_wr    <= pend ? req_wr    : wr;
    end
  end

  AST_BEGIN_AT_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> (qtr == QTR_1)); // R10

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !boundary) |=> $stable(req_addr)); // R10

  AST_CYCLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cyc_end) |=> $stable(cyc_addr)); // R10

endmodule

// File: rtl/qpm_pinmux.sv
module qpm_pinmux
  import qpm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int AX_BASE = 20,
  parameter int COL_BIT = 14,
  parameter int ROM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qtr_e              qtr,
  input  logic              active,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  input  logic              cyc_wr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              xa_hi,
  output logic              xa_lo,
  output logic              xa_ext,
  output logic              buf_en_n,
  output logic              rom_en_n
);

  localparam int NBYTES = DATA_W / 8;
  localparam int ROM_AW = $clog2(ROM_WORDS);

  logic [DATA_W-1:0] par_src;
  logic [NBYTES-1:0] byte_par;
  logic [3:0]        ax;
  logic              rom_window;

  assign par_src = cyc_wr ? cyc_wdata : rd_data;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_par
      assign byte_par[gb] = odd_par(par_src[gb*8 +: 8]);
    end
  endgenerate

  assign ax         = cyc_addr[AX_BASE +: 4];
  assign rom_window = (cyc_addr[ADDR_W-1:ROM_AW] == '0);

  always_comb begin
    case (qtr)
      QTR_1: begin
        xa_hi  = ax[1];
        xa_lo  = ax[3];
        xa_ext = ax[2];
      end
      QTR_2: begin
        xa_hi  = ax[0];
        xa_lo  = ax[2];
        xa_ext = cyc_addr[COL_BIT];
      end
      default: begin
        xa_hi  = byte_par[NBYTES-1];
        xa_lo  = byte_par[0];
        xa_ext = cyc_addr[COL_BIT];
      end
    endcase
  end

  assign buf_en_n = !(active && data_half(qtr));
  assign rom_en_n = !(active && !cyc_wr && rom_window);

  AST_PAR_ODD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cyc_wr && data_half(qtr)) |-> (^{xa_hi, cyc_wdata[DATA_W-1 -: 8]})); // R7

  AST_BUF_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en_n |-> (active && (qtr != QTR_1) && (qtr != QTR_2))); // R8

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en_n |-> (!cyc_wr && (cyc_addr < ADDR_W'(ROM_WORDS)))); // R9

endmodule

// File: rtl/qphase_membus.sv
module qphase_membus
  import qpm_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int SLOW_DIV  = 2,
  parameter int AX_BASE   = 20,
  parameter int COL_BIT   = 14,
  parameter int ROM_WORDS = 16
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              div_sel,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bclk_lead,
  output logic              bclk_lag,
  output logic              xa_hi,
  output logic              xa_lo,
  output logic              xa_ext,
  output logic              buf_en_n,
  output logic              rom_en_n
);

  logic              tick;
  qtr_e              qtr;
  logic              active;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_wdata;
  logic              cyc_wr;
  logic              cyc_begin;
  logic              cyc_end;

  qpm_clkgen #(.SLOW_DIV(SLOW_DIV)) i_clkgen (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .div_sel   (div_sel),
    .tick      (tick),
    .qtr       (qtr),
    .bclk_lead (bclk_lead),
    .bclk_lag  (bclk_lag)
  );

  qpm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .qtr       (qtr),
    .start     (start),
    .addr      (addr),
    .wdata     (wdata),
    .wr        (wr),
    .active    (active),
    .cyc_addr  (cyc_addr),
    .cyc_wdata (cyc_wdata),
    .cyc_wr    (cyc_wr),
    .cyc_begin (cyc_begin),
    .cyc_end   (cyc_end)
  );

  qpm_pinmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AX_BASE(AX_BASE),
    .COL_BIT(COL_BIT), .ROM_WORDS(ROM_WORDS)
  ) i_pinmux (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .qtr       (qtr),
    .active    (active),
    .cyc_addr  (cyc_addr),
    .cyc_wdata (cyc_wdata),
    .cyc_wr    (cyc_wr),
    .rd_data   (rd_data),
    .xa_hi     (xa_hi),
    .xa_lo     (xa_lo),
    .xa_ext    (xa_ext),
    .buf_en_n  (buf_en_n),
    .rom_en_n  (rom_en_n)
  );

  AST_BEGIN_NOT_BUSY: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cyc_begin |=> (active && !buf_en_n == 1'b0)); // R10

  AST_END_IDLES: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cyc_end |=> (buf_en_n && rom_en_n)); // R8

endmodule

// File: tb/test_qphase_membus.sv
module test_qphase_membus;

  logic        osc_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        div_sel = 1'b1;
  logic        start   = 1'b0;
  logic [23:0] addr    = '0;
  logic [15:0] wdata   = '0;
  logic        wr      = 1'b0;
  logic [15:0] rd_data = '0;
  logic        bclk_lead, bclk_lag, xa_hi, xa_lo, xa_ext, buf_en_n, rom_en_n;

  int total = 0;
  int bad   = 0;
  int cyc_count = 0;

  always #4 osc_clk = ~osc_clk;

  qphase_membus i_qphase_membus (
    .osc_clk(osc_clk), .rst_n(rst_n), .div_sel(div_sel), .start(start),
    .addr(addr), .wdata(wdata), .wr(wr), .rd_data(rd_data),
    .bclk_lead(bclk_lead), .bclk_lag(bclk_lag), .xa_hi(xa_hi), .xa_lo(xa_lo),
    .xa_ext(xa_ext), .buf_en_n(buf_en_n), .rom_en_n(rom_en_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // quarter index 1..4 from the clock pair
  function automatic int quarter();
    case ({bclk_lead, bclk_lag})
      2'b10:   return 1;
      2'b11:   return 2;
      2'b01:   return 3;
      default: return 4;
    endcase
  endfunction

  function automatic bit par_odd(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return (ones % 2) == 0;
  endfunction

  function automatic bit want_hi(input int q, input logic [23:0] a, input logic [15:0] d);
    if (q == 1) return a[21];
    if (q == 2) return a[20];
    return par_odd(d[15:8]);
  endfunction

  function automatic bit want_lo(input int q, input logic [23:0] a, input logic [15:0] d);
    if (q == 1) return a[23];
    if (q == 2) return a[22];
    return par_odd(d[7:0]);
  endfunction

  function automatic bit want_ext(input int q, input logic [23:0] a);
    return (q == 1) ? a[22] : a[14];
  endfunction

  // one transaction; dbl: second strobe one cycle later, poke: strobe in Q2 of the cycle
  task automatic run_txn(input logic [23:0] a, input bit w, input logic [15:0] wd,
                         input logic [15:0] rd, input bit dv, input bit dbl, input bit poke);
    int prev, q, guard;
    bit in_cyc, done, poked;
    logic [15:0] pd;
    bit rom_exp;
    @(negedge osc_clk);
    div_sel = dv; addr = a; wdata = wd; wr = w; rd_data = rd; start = 1'b1;
    prev = quarter();
    pd = w ? wd : rd;
    rom_exp = !w && (a < 24'h10);
    in_cyc = 0; done = 0; poked = 0; guard = 0;
    while (!done && guard < 100) begin
      @(negedge osc_clk);
      guard++;
      if (guard == 1 && dbl) begin
        addr = ~a; wr = ~w; wdata = ~wd; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      q = quarter();
      if (!in_cyc) begin
        if (q == 1 && prev != 1) in_cyc = 1;
      end else if (q == 1 && prev == 4) begin
        done = 1;
        chk(buf_en_n === 1'b1, "R8 idle after cycle", buf_en_n, 1);
        chk(rom_en_n === 1'b1, "R9 idle after cycle", rom_en_n, 1);
      end
      if (in_cyc && !done) begin
        chk(xa_hi === want_hi(q, a, pd), "R4 xa_hi", xa_hi, want_hi(q, a, pd));
        chk(xa_lo === want_lo(q, a, pd), "R5 xa_lo", xa_lo, want_lo(q, a, pd));
        chk(xa_ext === want_ext(q, a), "R6 xa_ext", xa_ext, want_ext(q, a));
        if (q >= 3) chk(^{xa_hi, pd[15:8]} === 1'b1, "R7 odd parity", xa_hi, ~^pd[15:8]);
        chk(buf_en_n === (q < 3), "R8 buf_en_n", buf_en_n, (q < 3));
        chk(rom_en_n === !rom_exp, "R9 rom_en_n", rom_en_n, !rom_exp);
        if (poke && q == 2 && !poked) begin
          start = 1'b1; addr = 24'h000003; wr = 1'b0; poked = 1;
        end
      end
      prev = q;
    end
    chk(done, "R10 cycle completed", done, 1);
    if (poke || dbl) begin
      // the whole next frame must stay idle: later strobes were ignored
      done = 0; guard = 0;
      while (!done && guard < 40) begin
        @(negedge osc_clk);
        guard++;
        q = quarter();
        if (q == 1 && prev == 4) done = 1;
        else begin
          chk(buf_en_n === 1'b1, "R10 ignored strobe buf", buf_en_n, 1);
          chk(rom_en_n === 1'b1, "R10 ignored strobe rom", rom_en_n, 1);
        end
        prev = q;
      end
    end
  endtask

  // R1/R2/R3: period and lag in oscillator cycles
  task automatic measure(input bit dv, input int per_exp, input int lag_exp);
    int n, rise_at, lag_at, prev_lead, prev_lag;
    @(negedge osc_clk);
    div_sel = dv;
    repeat (10) @(negedge osc_clk);
    prev_lead = bclk_lead; prev_lag = bclk_lag;
    rise_at = -1; lag_at = -1;
    n = 0;
    while (n < 40) begin
      @(negedge osc_clk);
      n++;
      if (bclk_lag && !prev_lag && rise_at >= 0 && lag_at < 0) lag_at = n;
      if (bclk_lead && !prev_lead) begin
        if (rise_at >= 0) begin
          chk((n - rise_at) == per_exp, dv ? "R2 period" : "R3 period", n - rise_at, per_exp);
          chk((lag_at - rise_at) == lag_exp, "R1 lag", lag_at - rise_at, lag_exp);
          break;
        end
        rise_at = n;
      end
      prev_lead = bclk_lead; prev_lag = bclk_lag;
    end
  endtask

  initial begin
    forever begin
      @(posedge osc_clk);
      cyc_count++;
      if (cyc_count > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc_count);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge osc_clk);
    chk(bclk_lead === 1'b1 && bclk_lag === 1'b0, "R11 reset Q1", {bclk_lead, bclk_lag}, 2'b10);
    chk(buf_en_n === 1'b1, "R11 reset buf", buf_en_n, 1);
    chk(rom_en_n === 1'b1, "R11 reset rom", rom_en_n, 1);
    rst_n = 1'b1;

    measure(1'b1, 8, 2);
    measure(1'b0, 4, 1);

    // directed: ROM read, ROM write, edge of window, parity from read bus
    run_txn(24'h00000F, 1'b0, 16'h1234, 16'h00FF, 1'b1, 0, 0);
    run_txn(24'h000004, 1'b1, 16'h0101, 16'hFFFF, 1'b0, 0, 0);
    run_txn(24'h000010, 1'b0, 16'h0000, 16'h8001, 1'b1, 0, 0);
    run_txn(24'hF04000, 1'b1, 16'hA5C3, 16'h0000, 1'b0, 0, 0);
    run_txn(24'h5A0000, 1'b0, 16'hFFFF, 16'h7F80, 1'b1, 1, 0);
    run_txn(24'h000002, 1'b0, 16'h0000, 16'h1111, 1'b0, 0, 1);

    for (int t = 0; t < 60; t++) begin
      logic [23:0] ra;
      ra = $urandom();
      if ($urandom_range(2) == 0) ra = 24'($urandom_range(31));
      run_txn(ra, 1'($urandom()), 16'($urandom()), 16'($urandom()), 1'($urandom()),
              ($urandom_range(4) == 0), ($urandom_range(4) == 0));
      repeat ($urandom_range(5)) @(negedge osc_clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule